// File: doc/BRIEF.md
# Pin Transition Interrupt Detector

This block watches a group of input pins and records selected transitions on them. Each pin first passes through a synchroniser. Its synchronised level is then compared with the level from the previous cycle to find rising and falling edges. Every pin has its own rising-edge enable and its own falling-edge enable, so it can report rising edges, falling edges, both, or neither. An enabled edge sets a sticky status bit for that pin.

The status bits are ORed into a single interrupt request for the interrupt controller. Software reads the enables and the status over a small register port and clears status bits by writing ones to them. Detection reads only the raw level on each pin and does not depend on what the pin is used for elsewhere.

Register map: address 0 holds the rising-edge enables, address 1 holds the falling-edge enables, address 2 is the status register (read, write-one-to-clear), and address 3 reads as zero. In every register, bit i belongs to `pins_in[i]`.

Top module: `io_edge_irq`

## Requirements
- R1: After reset, both enable registers and the status register read zero and `irq` is low.
- R2: A low-to-high change on `pins_in[i]`, with bit i set in the rising-enable register (address 0), sets status bit i. The bit becomes visible after the third rising clock edge that follows the change.
- R3: A high-to-low change on `pins_in[i]`, with bit i set in the falling-enable register (address 1), sets status bit i with the same three-edge latency.
- R4: A transition whose direction is not enabled for that pin leaves the status register unchanged.
- R5: A status bit stays set until a write to address 2 with data bit i equal to 1. Data bits equal to 0 leave their status bits unchanged, and writes to the enable registers never change status.
- R6: If an enabled edge is latched in the same clock edge as a clear write to that bit, the bit ends up set.
- R7: `irq` is high exactly when at least one status bit is set.
- R8: Pins are detected independently. Enabled edges on several pins in the same cycle each set their own status bit.
- R9: Writes to addresses 0 and 1 are read back unchanged on `rd_data` at the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_in | input | N_PINS | Asynchronous pins to monitor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | N_PINS | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | N_PINS | Combinational read data |
| irq | output | 1 | I/O status interrupt request |

## Verification
Latching a fresh edge and a software clear of the same status bit can occur in the same clock edge. The bench first sets a pin's bit with one edge. It then applies the opposite edge and times a write-one-to-clear so that the clear lands in the exact cycle the edge is latched. The bit must remain set, while another bit cleared in the same write must drop. A plain clear with no edge pending is checked separately to show that the clear alone works.

// File: rtl/io_edge_irq.sv
module io_edge_irq #(
  parameter int N_PINS      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [N_PINS-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [N_PINS-1:0] rd_data,
  output logic              irq
);

  localparam logic [1:0] ADDR_RISE = 2'd0;
  localparam logic [1:0] ADDR_FALL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  logic [N_PINS-1:0] sync_q [SYNC_STAGES];
  logic [N_PINS-1:0] level_prev;
  logic [N_PINS-1:0] rise_en, fall_en, status;
  logic [N_PINS-1:0] hit, clr;
  logic [N_PINS-1:0] level;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pins_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) level_prev <= '0;
    else        level_prev <= level;
  end

  assign hit = (rise_en & level & ~level_prev) | (fall_en & ~level & level_prev);
  assign clr = (wr_en && wr_addr == ADDR_STAT) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      status  <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_RISE) rise_en <= wr_data;
      if (wr_en && wr_addr == ADDR_FALL) fall_en <= wr_data;
      status <= (status & ~clr) | hit;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_RISE: rd_data = rise_en;
      ADDR_FALL: rd_data = fall_en;
      ADDR_STAT: rd_data = status;
      default:   rd_data = '0;
    endcase
  end

  assign irq = |status;

endmodule

// File: rtl/io_edge_irq_chk.sv
module io_edge_irq_chk #(
  parameter int N_PINS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [N_PINS-1:0] wr_data,
  input logic [N_PINS-1:0] hit,
  input logic [N_PINS-1:0] status,
  input logic              irq
);

  for (genvar i = 0; i < N_PINS; i++) begin : g_bit
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(wr_en && wr_addr == 2'd2 && wr_data[i])) |=> status[i]);

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && wr_en && wr_addr == 2'd2 && wr_data[i] && !hit[i]) |=> !status[i]);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> status[i]);

    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[i] && !hit[i]) |=> !status[i]);
  end

  a_r7_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|hit));

  a_r7_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && wr_addr == 2'd2));

endmodule

bind io_edge_irq io_edge_irq_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .hit(hit), .status(status), .irq(irq)
);

// File: tb/sim_io_edge_irq.sv
module sim_io_edge_irq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins_in = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  io_edge_irq #(.N_PINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic check_status(input string req, input logic [N-1:0] exp);
    logic [N-1:0] d;
    rd(2'd2, d);
    check(req, d, exp);
    check({req, " irq"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |exp});
  endtask

  initial begin
    logic [N-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); check("R1 rise_en", d, '0);
    rd(2'd1, d); check("R1 fall_en", d, '0);
    check_status("R1 status", '0);
    rd(2'd3, d); check("R1 addr3", d, '0);

    wr(2'd0, 6'b101101); wr(2'd1, 6'b010110);
    rd(2'd0, d); check("R9 rise readback", d, 6'b101101);
    rd(2'd1, d); check("R9 fall readback", d, 6'b010110);

    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [N-1:0] rmask, fmask;
        rmask = m[0] ? (N'(1) << i) : '0;
        fmask = m[1] ? (N'(1) << i) : '0;
        wr(2'd0, rmask); wr(2'd1, fmask);
        repeat (4) @(negedge clk);
        wr(2'd2, '1);
        check_status("R5 cleared", '0);
        pins_in[i] = 1'b1;
        repeat (3) @(negedge clk);
        check_status(m[0] ? "R2 rise latched" : "R4 rise ignored", rmask);
        wr(2'd2, '0);
        check_status("R5 zero write keeps", rmask);
        wr(2'd0, '0);
        check_status("R5 enable write keeps", rmask);
        wr(2'd0, rmask);
        wr(2'd2, '1);
        check_status("R5 w1c", '0);
        pins_in[i] = 1'b0;
        repeat (3) @(negedge clk);
        check_status(m[1] ? "R3 fall latched" : "R4 fall ignored", fmask);
        wr(2'd2, '1);
      end
    end

    wr(2'd0, '1); wr(2'd1, '1);
    pins_in = '1;
    repeat (3) @(negedge clk);
    check_status("R8 all pins rise", '1);
    wr(2'd2, 6'b000101);
    check_status("R8 partial clear", 6'b111010);
    wr(2'd2, '1);
    pins_in = 6'b010101;
    repeat (3) @(negedge clk);
    check_status("R8 mixed fall", 6'b101010);
    wr(2'd2, '1);
    pins_in = 6'b000000;
    repeat (3) @(negedge clk);
    check_status("R8 second fall", 6'b010101);
    wr(2'd2, '1);

    pins_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    check_status("R2 pre set-wins", 6'b000001);
    pins_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    check_status("R2 second bit", 6'b000011);
    pins_in[0] = 1'b0;
    repeat (2) @(negedge clk);
    wr(2'd2, 6'b000011);
    check_status("R6 edge beats clear", 6'b000001);
    wr(2'd2, 6'b000001);
    check_status("R6 later clear", '0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule